// File: doc/BRIEF.md
# Serial Memory Slave Engine

This block is the serial-bus slave side of a byte-wide memory whose writes finish at once. A host selects it with an active-low select line, clocks bits in on one data line and reads them back on another. The first complete byte after each select is a command; memory commands are followed by a three-byte address, after which data bytes stream into or out of an internal array. The address moves forward after every byte and wraps from the top location to zero. There is no busy state: a byte is in the array as soon as its eighth bit has arrived.

All bus pins are treated as levels sampled by the core clock `clk`. Bus clock edges are found by comparing each sample with the one before, so the core clock must run several times faster than the bus clock. The array depth is set by `ADDR_W`. Only the low `ADDR_W` bits of the address on the wire are used. The write-enable latch, the block-protection policy and the low-power state are kept in neighbouring blocks. This engine reports commands to them through one-cycle strobes, takes a per-byte write permit and a status byte from them, and shows them the current byte address.

Top module: `spi_mem_engine`

## Requirements
- R1: The first eight bits after select falls form the command, most significant bit first. Only one command is taken per select: further bytes in the same select are never decoded as commands.
- R2: Command 02h, then three address bytes, then data bytes writes each data byte into the array. The write happens in the core cycle after the byte's eighth rising bus-clock edge is seen, and only if `wr_permit_i` is high at that time.
- R3: Command 03h, then three address bytes, returns array bytes most significant bit first. Output bits change after falling bus-clock edges, and the first bit is valid before the first rising edge that follows the address.
- R4: Command 0Bh works like 03h, except that one ignored dummy byte follows the address before data starts.
- R5: After each data byte, the address moves to the next location. From location 2^ADDR_W-1 it wraps to 0, for both reads and writes.
- R6: Address bits above the low `ADDR_W` bits are ignored.
- R7: If select rises with a data byte only partly received, that byte is dropped and nothing is written.
- R8: `spi_miso_oe` is high only while select is low, hold is inactive, and a read-data phase has begun (the first falling edge after the command, address and dummy bytes). It is low after reset and while deselected.
- R9: If `spi_hold_n` goes low while the bus clock is low, the transfer pauses: bus-clock and select changes are ignored and `spi_miso_oe` is low. When hold returns high with the bus clock low, the transfer carries on where it stopped.
- R10: An unknown command makes the rest of that select do nothing: no write, no strobe, output enable low.
- R11: After a complete command byte, select rising produces one one-cycle strobe: 06h gives `wel_set_o`, 04h gives `wel_clr_o`, B9h gives `sleep_o`. A partial command byte gives no strobe.
- R12: Command 05h shifts out `status_i` and repeats it for every further byte. Command 01h passes its next complete byte on `sr_wdata_o`, with a one-cycle `sr_wr_o` pulse.
- R13: When `wr_permit_i` is low, data bytes are not stored. Select rising after a 02h command that reached its data phase pulses `wr_done_o` once, whether or not bytes were stored.
- R14: Transfers work the same whether the bus clock idles low or idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sck | input | 1 | Bus clock |
| spi_mosi | input | 1 | Serial data from host |
| spi_hold_n | input | 1 | Active-low pause |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; low means high impedance |
| status_i | input | 8 | Status byte returned by command 05h |
| wr_permit_i | input | 1 | Permit for the byte being written at addr_o |
| addr_o | output | ADDR_W | Current byte address |
| wel_set_o | output | 1 | Strobe for command 06h |
| wel_clr_o | output | 1 | Strobe for command 04h |
| sleep_o | output | 1 | Strobe for command B9h |
| wr_done_o | output | 1 | Strobe at end of a write command |
| sr_wr_o | output | 1 | Strobe with a status write byte |
| sr_wdata_o | output | 8 | Status write byte |

## Verification
The bench builds the engine with `ADDR_W` = 6, so the array has 64 locations. At that depth, one burst fills the whole array and the wrap from 63 to 0 can be reached by both reads and writes. Addresses with nonzero upper bits show that those bits alias onto the same small array. Every transfer runs in the mode where the bus clock idles low, and one write/read pair is repeated with the bus clock idling high.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] CMD_WEN_SET = 8'h06;
  localparam logic [7:0] CMD_WEN_CLR = 8'h04;
  localparam logic [7:0] CMD_ST_RD   = 8'h05;
  localparam logic [7:0] CMD_ST_WR   = 8'h01;
  localparam logic [7:0] CMD_RD      = 8'h03;
  localparam logic [7:0] CMD_RD_FAST = 8'h0B;
  localparam logic [7:0] CMD_WR      = 8'h02;
  localparam logic [7:0] CMD_NAP     = 8'hB9;

  typedef enum logic [3:0] {
    PH_CMD, PH_ADDR, PH_DUMMY, PH_RDATA, PH_WDATA,
    PH_STRD, PH_STWR, PH_NODATA, PH_IGNORE
  } phase_t;

  typedef enum logic [3:0] {
    K_NONE, K_WEN_SET, K_WEN_CLR, K_NAP, K_RD, K_RD_FAST, K_WR, K_ST_RD, K_ST_WR
  } kind_t;

  function automatic kind_t cmd_kind(input logic [7:0] b);
    case (b)
      CMD_WEN_SET: return K_WEN_SET;
      CMD_WEN_CLR: return K_WEN_CLR;
      CMD_NAP:     return K_NAP;
      CMD_RD:      return K_RD;
      CMD_RD_FAST: return K_RD_FAST;
      CMD_WR:      return K_WR;
      CMD_ST_RD:   return K_ST_RD;
      CMD_ST_WR:   return K_ST_WR;
      default:     return K_NONE;
    endcase
  endfunction

  function automatic logic is_out_phase(input phase_t p);
    return (p == PH_RDATA) || (p == PH_STRD);
  endfunction

endpackage

// File: rtl/spi_mem_front.sv
module spi_mem_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic sel,
  output logic sel_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic held
);

  logic cs_eff, cs_prev, sck_q;

  // hold only changes state while the bus clock is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= 1'b0;
      cs_eff  <= 1'b1;
      cs_prev <= 1'b1;
      sck_q   <= 1'b0;
    end else begin
      if (!sck) held <= !hold_n;
      if (!held) cs_eff <= cs_n;
      cs_prev <= cs_eff;
      sck_q   <= sck;
    end
  end

  assign sel      = !cs_eff;
  assign sel_end  = cs_eff && !cs_prev;
  assign sck_rise = sel && !held && sck && !sck_q;
  assign sck_fall = sel && !held && !sck && sck_q;

endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_end,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi,
  input  logic [7:0]        status_i,
  input  logic              wr_permit_i,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [7:0]        mem_wdata,
  output logic              miso,
  output logic              drive,
  output logic              byte_done,
  output logic              addr_adv,
  output logic              in_ignore,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              sleep_o,
  output logic              wr_done_o,
  output logic              sr_wr_o,
  output logic [7:0]        sr_wdata_o
);

  localparam int WIRE_W = 8 * ADDR_BYTES;
  localparam int HI_W   = WIRE_W - 8;
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] trim_addr(input logic [WIRE_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  phase_t            phase;
  kind_t             kind;
  logic [2:0]        bitcnt;
  logic [7:0]        rx, tx;
  logic [1:0]        abyte;
  logic [HI_W-1:0]   ahi;
  logic              wrote;
  logic [7:0]        rx_next;
  logic [WIRE_W-1:0] addr_full;
  logic [ADDR_W-1:0] new_addr;

  assign rx_next   = {rx[6:0], mosi};
  assign byte_done = sck_rise && (bitcnt == 3'd7);
  assign addr_full = {ahi, rx_next};
  assign new_addr  = trim_addr(addr_full);
  assign mem_we    = byte_done && (phase == PH_WDATA) && wr_permit_i;
  assign mem_wdata = rx_next;
  assign addr_adv  = byte_done && ((phase == PH_WDATA) || (phase == PH_RDATA));
  assign in_ignore = (phase == PH_IGNORE);

  // single read port: look ahead to the byte loaded at the next boundary
  always_comb begin
    case (phase)
      PH_ADDR:  raddr = new_addr;
      PH_DUMMY: raddr = cur_addr;
      default:  raddr = step_addr(cur_addr);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      kind       <= K_NONE;
      bitcnt     <= '0;
      rx         <= '0;
      tx         <= '0;
      abyte      <= '0;
      ahi        <= '0;
      cur_addr   <= '0;
      wrote      <= 1'b0;
      drive      <= 1'b0;
      miso       <= 1'b0;
      wel_set_o  <= 1'b0;
      wel_clr_o  <= 1'b0;
      sleep_o    <= 1'b0;
      wr_done_o  <= 1'b0;
      sr_wr_o    <= 1'b0;
      sr_wdata_o <= '0;
    end else begin
      wel_set_o <= 1'b0;
      wel_clr_o <= 1'b0;
      sleep_o   <= 1'b0;
      wr_done_o <= 1'b0;
      sr_wr_o   <= 1'b0;
      if (!sel) begin
        if (sel_end) begin
          if (phase == PH_NODATA) begin
            wel_set_o <= (kind == K_WEN_SET);
            wel_clr_o <= (kind == K_WEN_CLR);
            sleep_o   <= (kind == K_NAP);
          end
          wr_done_o <= wrote;
        end
        phase  <= PH_CMD;
        kind   <= K_NONE;
        bitcnt <= '0;
        rx     <= '0;
        abyte  <= '0;
        wrote  <= 1'b0;
        drive  <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx     <= rx_next;
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              kind <= cmd_kind(rx_next);
              case (cmd_kind(rx_next))
                K_WEN_SET, K_WEN_CLR, K_NAP: phase <= PH_NODATA;
                K_RD, K_RD_FAST, K_WR: begin
                  phase <= PH_ADDR;
                  abyte <= '0;
                end
                K_ST_RD: begin
                  phase <= PH_STRD;
                  tx    <= status_i;
                end
                K_ST_WR: phase <= PH_STWR;
                default: phase <= PH_IGNORE;
              endcase
            end
            PH_ADDR: begin
              if (abyte == 2'(ADDR_BYTES - 1)) begin
                cur_addr <= new_addr;
                case (kind)
                  K_RD: begin
                    phase <= PH_RDATA;
                    tx    <= rdata;
                  end
                  K_RD_FAST: phase <= PH_DUMMY;
                  default: begin
                    phase <= PH_WDATA;
                    wrote <= 1'b1;
                  end
                endcase
              end else begin
                ahi   <= {ahi[HI_W-9:0], rx_next};
                abyte <= abyte + 2'd1;
              end
            end
            PH_DUMMY: begin
              phase <= PH_RDATA;
              tx    <= rdata;
            end
            PH_RDATA: begin
              cur_addr <= step_addr(cur_addr);
              tx       <= rdata;
            end
            PH_WDATA: cur_addr <= step_addr(cur_addr);
            PH_STRD:  tx <= status_i;
            PH_STWR: begin
              sr_wr_o    <= 1'b1;
              sr_wdata_o <= rx_next;
              phase      <= PH_NODATA;
            end
            default: ;
          endcase
        end
        if (sck_fall && is_out_phase(phase)) begin
          miso  <= tx[7];
          tx    <= {tx[6:0], 1'b0};
          drive <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
  parameter int ADDR_W     = 10,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_hold_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [7:0]        status_i,
  input  logic              wr_permit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              sleep_o,
  output logic              wr_done_o,
  output logic              sr_wr_o,
  output logic [7:0]        sr_wdata_o
);

  logic              sel, sel_end, sck_rise, sck_fall, held;
  logic [ADDR_W-1:0] raddr, cur_addr;
  logic [7:0]        rdata, mem_wdata;
  logic              mem_we, drive, byte_done, addr_adv, in_ignore;

  spi_mem_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .hold_n(spi_hold_n),
    .sel(sel), .sel_end(sel_end), .sck_rise(sck_rise), .sck_fall(sck_fall), .held(held)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sel_end(sel_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(spi_mosi),
    .status_i(status_i), .wr_permit_i(wr_permit_i), .rdata(rdata),
    .raddr(raddr), .mem_we(mem_we), .cur_addr(cur_addr), .mem_wdata(mem_wdata),
    .miso(spi_miso), .drive(drive), .byte_done(byte_done), .addr_adv(addr_adv),
    .in_ignore(in_ignore), .wel_set_o(wel_set_o), .wel_clr_o(wel_clr_o),
    .sleep_o(sleep_o), .wr_done_o(wr_done_o), .sr_wr_o(sr_wr_o), .sr_wdata_o(sr_wdata_o)
  );

  spi_mem_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(cur_addr), .wdata(mem_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign spi_miso_oe = drive && sel && !held;
  assign addr_o      = cur_addr;

endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso_oe,
  input logic              wr_permit_i,
  input logic              held,
  input logic              byte_done,
  input logic              mem_we,
  input logic              addr_adv,
  input logic              in_ignore,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              wel_set_o,
  input logic              wel_clr_o,
  input logic              sleep_o
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  assert_oe_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso_oe);

  assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!byte_done && !spi_miso_oe));

  assert_write_on_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> byte_done);

  assert_write_permit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_permit_i);

  assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_adv && cur_addr == TOP) |=> (cur_addr == '0));

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set_o, wel_clr_o, sleep_o}));

  assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wel_set_o |=> !wel_set_o);

  assert_ignore_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ignore |-> (!spi_miso_oe && !mem_we));

endmodule

bind spi_mem_engine spi_mem_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .wr_permit_i(wr_permit_i), .held(held), .byte_done(byte_done), .mem_we(mem_we),
  .addr_adv(addr_adv), .in_ignore(in_ignore), .cur_addr(cur_addr),
  .wel_set_o(wel_set_o), .wel_clr_o(wel_clr_o), .sleep_o(sleep_o)
);

// File: tb/spi_mem_engine_tb.sv
module spi_mem_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 6;
  localparam int SIZE = 1 << AW;

  // {24-bit wire address, data}
  localparam logic [31:0] VEC [8] = '{
    {24'h000003, 8'h5A}, {24'h00000F, 8'hC3}, {24'h000021, 8'h00},
    {24'h00002A, 8'hFF}, {24'h000035, 8'h81}, {24'h00003E, 8'h7E},
    {24'h000017, 8'h19}, {24'h000008, 8'hE4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe;
  logic [7:0] status = 8'h00;
  logic permit = 1'b1;
  logic [AW-1:0] addr_o;
  logic wel_set, wel_clr, nap, wr_done, sr_wr;
  logic [7:0] sr_wdata;

  int total = 0, bad = 0, cycles = 0;
  int n_set = 0, n_clr = 0, n_nap = 0, n_done = 0, n_srw = 0;
  logic [7:0] last_sr = 8'h00;
  logic [7:0] model [SIZE];
  logic [7:0] wbuf [SIZE];
  logic [7:0] rbuf [SIZE];
  logic oe_all, oe_any;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_engine #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .status_i(status),
    .wr_permit_i(permit), .addr_o(addr_o), .wel_set_o(wel_set), .wel_clr_o(wel_clr),
    .sleep_o(nap), .wr_done_o(wr_done), .sr_wr_o(sr_wr), .sr_wdata_o(sr_wdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
    if (nap) n_nap++;
    if (wr_done) n_done++;
    if (sr_wr) begin n_srw++; last_sr = sr_wdata; end
    if (miso_oe) oe_any = 1'b1;
    if (cycles > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic r);
    @(negedge clk); sck = 1'b0; mosi = b;
    repeat (4) @(negedge clk);
    r = miso; oe_all = oe_all & miso_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic byte_io(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_io(t[i], r[i]);
  endtask

  task automatic sel_on(input logic m3);
    @(negedge clk); sck = m3;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off(input logic m3);
    @(negedge clk); if (!m3) sck = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    byte_io(op, d); byte_io(a[23:16], d); byte_io(a[15:8], d); byte_io(a[7:0], d);
  endtask

  task automatic mem_write(input logic [23:0] a, input int n, input logic m3, input int extra);
    logic [7:0] d;
    logic r;
    sel_on(m3);
    send_hdr(8'h02, a);
    for (int i = 0; i < n; i++) begin
      byte_io(wbuf[i], d);
      if (permit) model[(a[AW-1:0] + i) % SIZE] = wbuf[i];
    end
    for (int i = 0; i < extra; i++) bit_io(1'b1, r);
    sel_off(m3);
  endtask

  task automatic mem_read(input logic fast, input logic [23:0] a, input int n, input logic m3);
    logic [7:0] d;
    sel_on(m3);
    send_hdr(fast ? 8'h0B : 8'h03, a);
    if (fast) byte_io(8'h00, d);
    oe_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      byte_io(8'hFF, d);
      rbuf[i] = d;
    end
    sel_off(m3);
  endtask

  task automatic one_byte_cmd(input logic [7:0] op, input int nbits);
    logic r;
    sel_on(1'b0);
    for (int i = 7; i > 7 - nbits; i--) bit_io(op[i], r);
    sel_off(1'b0);
  endtask

  initial begin
    int b_set, b_clr, b_nap, b_done;
    logic [7:0] d, h0, h1;
    logic r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state (R8, R11)
    chk(miso_oe == 1'b0, "R8 reset oe", miso_oe, 0);
    chk(n_set + n_clr + n_nap + n_done + n_srw == 0, "R11 reset strobes",
        n_set + n_clr + n_nap + n_done + n_srw, 0);

    // whole-array burst write, then burst read (R2, R3)
    for (int i = 0; i < SIZE; i++) wbuf[i] = 8'((i * 37 + 11) & 8'hFF);
    mem_write(24'h000000, SIZE, 1'b0, 0);
    mem_read(1'b0, 24'h000000, SIZE, 1'b0);
    for (int i = 0; i < SIZE; i += 9)
      chk(rbuf[i] == model[i], "R3 burst read", rbuf[i], model[i]);
    chk(rbuf[SIZE-1] == model[SIZE-1], "R2 burst last byte", rbuf[SIZE-1], model[SIZE-1]);
    chk(oe_all == 1'b1, "R8 oe during read data", oe_all, 1);

    // vector table: single-byte write then read back (R2, R3)
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][7:0];
      mem_write(VEC[v][31:8], 1, 1'b0, 0);
      mem_read(1'b0, VEC[v][31:8], 1, 1'b0);
      chk(rbuf[0] == VEC[v][7:0], "R2 vector write/read", rbuf[0], VEC[v][7:0]);
    end

    // fast read with dummy byte (R4)
    mem_read(1'b1, 24'h000014, 4, 1'b0);
    for (int i = 0; i < 4; i++)
      chk(rbuf[i] == model[20 + i], "R4 fast read", rbuf[i], model[20 + i]);

    // wrap at the top of the array (R5)
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    mem_write(24'(SIZE - 2), 4, 1'b0, 0);
    mem_read(1'b0, 24'(SIZE - 1), 3, 1'b0);
    chk(rbuf[0] == 8'hB2, "R5 read top", rbuf[0], 8'hB2);
    chk(rbuf[1] == 8'hC3, "R5 write/read wrap to 0", rbuf[1], 8'hC3);
    chk(rbuf[2] == 8'hD4, "R5 wrap to 1", rbuf[2], 8'hD4);
    mem_read(1'b1, 24'(SIZE - 1), 2, 1'b0);
    chk(rbuf[1] == 8'hC3, "R5 fast read wrap", rbuf[1], 8'hC3);

    // upper address bits ignored (R6)
    wbuf[0] = 8'h77;
    mem_write(24'hABCD05, 1, 1'b0, 0);
    mem_read(1'b0, 24'h000005, 1, 1'b0);
    chk(rbuf[0] == 8'h77, "R6 aliased write", rbuf[0], 8'h77);
    mem_read(1'b0, 24'h000045, 1, 1'b0);
    chk(rbuf[0] == 8'h77, "R6 aliased read", rbuf[0], 8'h77);

    // partial byte dropped (R7)
    wbuf[0] = 8'hA5;
    mem_write(24'h00000A, 1, 1'b0, 5);
    mem_read(1'b0, 24'h00000A, 2, 1'b0);
    chk(rbuf[0] == 8'hA5, "R7 full byte kept", rbuf[0], 8'hA5);
    chk(rbuf[1] == model[11], "R7 partial byte dropped", rbuf[1], model[11]);

    // hold in the middle of a read byte (R9)
    sel_on(1'b0);
    send_hdr(8'h03, 24'h00001E);
    for (int i = 7; i >= 4; i--) begin bit_io(1'b1, r); h0[i] = r; end
    @(negedge clk); sck = 1'b0;
    repeat (4) @(negedge clk);
    hold_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(miso_oe == 1'b0, "R9 oe off while held", miso_oe, 0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b0; repeat (4) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 3; i >= 0; i--) begin bit_io(1'b1, r); h0[i] = r; end
    byte_io(8'hFF, h1);
    sel_off(1'b0);
    chk(h0 == model[30], "R9 byte across hold", h0, model[30]);
    chk(h1 == model[31], "R9 next byte after hold", h1, model[31]);

    // unknown command ignored (R10)
    b_set = n_set; b_clr = n_clr; b_nap = n_nap; b_done = n_done;
    oe_any = 1'b0;
    sel_on(1'b0);
    byte_io(8'h5A, d); byte_io(8'h02, d); byte_io(8'h00, d);
    byte_io(8'h0C, d); byte_io(8'hEE, d); byte_io(8'h06, d);
    sel_off(1'b0);
    chk(oe_any == 1'b0, "R10 oe stays low", oe_any, 0);
    chk((n_set + n_clr + n_nap + n_done) == (b_set + b_clr + b_nap + b_done),
        "R10 no strobe", n_set + n_clr + n_nap + n_done, b_set + b_clr + b_nap + b_done);
    mem_read(1'b0, 24'h00000C, 1, 1'b0);
    chk(rbuf[0] == model[12], "R10 no write", rbuf[0], model[12]);

    // one-byte commands and single decode per select (R11, R1)
    b_set = n_set; one_byte_cmd(8'h06, 8);
    chk(n_set == b_set + 1, "R11 set strobe", n_set, b_set + 1);
    b_clr = n_clr; one_byte_cmd(8'h04, 8);
    chk(n_clr == b_clr + 1, "R11 clear strobe", n_clr, b_clr + 1);
    b_nap = n_nap; one_byte_cmd(8'hB9, 8);
    chk(n_nap == b_nap + 1, "R11 sleep strobe", n_nap, b_nap + 1);
    b_set = n_set; one_byte_cmd(8'h06, 5);
    chk(n_set == b_set, "R11 partial command no strobe", n_set, b_set);
    b_set = n_set; b_clr = n_clr;
    sel_on(1'b0); byte_io(8'h06, d); byte_io(8'h04, d); sel_off(1'b0);
    chk(n_set == b_set + 1, "R1 first byte decoded", n_set, b_set + 1);
    chk(n_clr == b_clr, "R1 second byte not decoded", n_clr, b_clr);

    // status read and status write (R12)
    status = 8'hC4;
    sel_on(1'b0); byte_io(8'h05, d);
    byte_io(8'h00, h0); byte_io(8'h00, h1); sel_off(1'b0);
    chk(h0 == 8'hC4, "R12 status byte", h0, 8'hC4);
    chk(h1 == 8'hC4, "R12 status repeated", h1, 8'hC4);
    b_set = n_srw;
    sel_on(1'b0); byte_io(8'h01, d); byte_io(8'h8C, d); sel_off(1'b0);
    chk(n_srw == b_set + 1, "R12 status write pulse", n_srw, b_set + 1);
    chk(last_sr == 8'h8C, "R12 status write data", last_sr, 8'h8C);

    // write permit withheld (R13)
    permit = 1'b0;
    b_done = n_done;
    wbuf[0] = ~model[40];
    mem_write(24'h000028, 1, 1'b0, 0);
    permit = 1'b1;
    chk(n_done == b_done + 1, "R13 write done strobe", n_done, b_done + 1);
    mem_read(1'b0, 24'h000028, 1, 1'b0);
    chk(rbuf[0] == model[40], "R13 blocked byte", rbuf[0], model[40]);

    // bus clock idling high (R14)
    wbuf[0] = 8'h3D; wbuf[1] = 8'h96;
    mem_write(24'h000032, 2, 1'b1, 0);
    mem_read(1'b0, 24'h000032, 2, 1'b1);
    chk(rbuf[0] == 8'h3D, "R14 idle-high byte 0", rbuf[0], 8'h3D);
    chk(rbuf[1] == 8'h96, "R14 idle-high byte 1", rbuf[1], 8'h96);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule